// File: doc/BRIEF.md
# Decode-Stage Branch Check and Fetch Redirect

This block sits beside the decode stage of an out-of-order core. Each cycle it receives a group of up to `WIDTH` instructions, in program order, each carrying a sequence number, a thread id, its control flags and the prediction that fetch attached to it. It looks for two kinds of wrong prediction. The first is an instruction that fetch marked as taken although it is not a control instruction. The second is a direct unconditional branch whose target, computed at decode, disagrees with the predicted target. Conditional and indirect control instructions are left for later stages.

When it finds a wrong prediction, the block raises a one-cycle redirect to fetch. The redirect carries the corrected next PC and the PC after it, a taken flag, the thread and a squash boundary sequence number. It also returns a kill mask over the same group: every slot of that thread whose sequence number is above the boundary is marked. A build-time option selects branch-delay-slot semantics. Under that option a target mismatch either squashes at once or waits until the delay-slot instruction has gone through, even when that instruction arrives in a later group. Two counters record wrong predictions and resolved branches.

Top module: `branch_redirect_check`

## Requirements
- R1: While reset is held and on the first cycle after it, `redirValid` is 0, `killMask` is all zeros and both counters read 0.
- R2: A valid instruction with `predTaken`=1 and `isCtrl`=0 causes a redirect whose next PC is its own `pc` + `INST_BYTES` and whose boundary is its own sequence number, in both modes.
- R3: A target is checked only for instructions with `isCtrl`, `isDirect` and `isUncond` all 1. A mismatch between `calcTarget` and `predTarget` then causes a redirect to `calcTarget`. Such a mismatch on a conditional or indirect control instruction, or on a non-control instruction, causes no redirect and no kill.
- R4: On every redirect, `redirNextNextPc` equals `redirNextPc` + `INST_BYTES`.
- R5: With `DELAY_SLOT`=0 the boundary is the offending instruction's sequence number. Bit i of `killMask` is set exactly when slot i was valid, belongs to the redirected thread and has a sequence number greater than the boundary. Slots of other threads are never marked.
- R6: At most one redirect is produced per group, taken from the lowest-numbered slot that triggers. Slots after it are not checked and are not counted.
- R7: With `DELAY_SLOT`=1, a target mismatch on a branch with `predTaken`=1 and `condDelay`=1 squashes at once, with the boundary at the branch's own sequence number.
- R8: With `DELAY_SLOT`=1, any other target mismatch sets the boundary to the branch sequence number + 1. The delay-slot instruction, which is the next valid slot of the same thread, is not killed. If that slot is in the same group, the redirect comes out for that group.
- R9: With `DELAY_SLOT`=1, if the deferred branch has no later same-thread slot in its group, no redirect is raised for that group. The redirect comes out for the first later group that holds a slot of that thread, using the saved branch's target and taken flag. While such a deferral is outstanding, slots of other threads pass through unchecked.
- R10: `redirTaken` is computed from the offending instruction. With `DELAY_SLOT`=0 it is `predTarget` != `pc` + `INST_BYTES`. With `DELAY_SLOT`=1 it is `predNextNext` != `predTarget` + `INST_BYTES`.
- R11: `mispredCount` rises by one for each instruction found wrongly predicted. `resolvedCount` rises by one for each checked direct unconditional control instruction, matched or not. A deferred branch is counted in the group where it is found.
- R12: All outputs are registered. A group presented before a rising edge shows its result after that edge, and `redirValid` is 0 for any cycle whose group causes no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | WIDTH | Slot holds an instruction |
| slotTid | input | WIDTH x TID_W | Thread id per slot |
| slotSeq | input | WIDTH x SEQ_W | Sequence number per slot |
| isCtrl | input | WIDTH | Instruction is a control instruction |
| isDirect | input | WIDTH | Target is PC-relative |
| isUncond | input | WIDTH | Control is unconditional |
| predTaken | input | WIDTH | Fetch predicted taken |
| condDelay | input | WIDTH | Delay slot of this branch is conditional |
| pc | input | WIDTH x PC_W | Instruction address |
| predTarget | input | WIDTH x PC_W | Predicted next PC |
| predNextNext | input | WIDTH x PC_W | Predicted PC after the next one |
| calcTarget | input | WIDTH x PC_W | Target computed at decode |
| redirValid | output | 1 | Redirect this cycle |
| redirTid | output | TID_W | Thread being redirected |
| redirNextPc | output | PC_W | Corrected next PC |
| redirNextNextPc | output | PC_W | Corrected PC after next |
| redirTaken | output | 1 | Offending instruction was predicted to leave the sequential path |
| squashSeq | output | SEQ_W | Squash boundary; younger same-thread instructions die |
| killMask | output | WIDTH | Slots of the group to be squashed |
| mispredCount | output | CNT_W | Wrong predictions found |
| resolvedCount | output | CNT_W | Direct unconditional branches checked |

## Verification
The bench builds two copies with four slots, 2-bit thread ids and 16-bit sequence numbers, one with `DELAY_SLOT`=0 and one with `DELAY_SLOT`=1. It drives the same groups into both copies, so every stimulus shows the immediate squash and the delay-slot squash side by side. Four slots leave room for a younger same-thread instruction after a delay slot, so the mask can be seen to move by one slot between modes. Mixed thread ids in one group show that other threads are never killed. A deferred branch placed in the last same-thread slot shows the hand-over to the next group, while the non-delay copy fires at once on the same input.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  localparam int STROBE_IDX_W = 8;

  // strobes from the scan control to the redirect datapath
  typedef struct packed {
    logic                    fire;      // raise a redirect this cycle
    logic                    useSaved;  // source is the held deferred branch
    logic                    plusOne;   // boundary is one past the source sequence
    logic                    pendLoad;  // hold the armed branch for a later group
    logic [STROBE_IDX_W-1:0] sel;       // source slot in the current group
    logic [STROBE_IDX_W-1:0] misInc;    // wrong predictions found this group
    logic [STROBE_IDX_W-1:0] resInc;    // branches resolved this group
  } bdcStrobe_t;

endpackage

// File: rtl/bdc_classify.sv
module bdc_classify #(
  parameter int WIDTH      = 4,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic [WIDTH-1:0]           slotValid,
  input  logic [WIDTH-1:0]           isCtrl,
  input  logic [WIDTH-1:0]           isDirect,
  input  logic [WIDTH-1:0]           isUncond,
  input  logic [WIDTH-1:0]           predTaken,
  input  logic [WIDTH-1:0]           condDelay,
  input  logic [WIDTH-1:0][PC_W-1:0] pc,
  input  logic [WIDTH-1:0][PC_W-1:0] predTarget,
  input  logic [WIDTH-1:0][PC_W-1:0] predNextNext,
  input  logic [WIDTH-1:0][PC_W-1:0] calcTarget,
  output logic [WIDTH-1:0]           immMiss,
  output logic [WIDTH-1:0]           deferMiss,
  output logic [WIDTH-1:0]           resolved,
  output logic [WIDTH-1:0][PC_W-1:0] fixTarget,
  output logic [WIDTH-1:0]           takenFlag
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  for (genvar g = 0; g < WIDTH; g++) begin : g_slot
    logic [PC_W-1:0] seqPc;
    logic            badCtrl;
    logic            checkable;
    logic            targetMiss;

    assign seqPc      = pc[g] + STEP;
    assign badCtrl    = slotValid[g] & predTaken[g] & ~isCtrl[g];
    assign checkable  = slotValid[g] & isCtrl[g] & isDirect[g] & isUncond[g];
    assign targetMiss = checkable & (calcTarget[g] != predTarget[g]);

    assign resolved[g]  = checkable;
    assign fixTarget[g] = badCtrl ? seqPc : calcTarget[g];

    if (DELAY_SLOT) begin : g_delay
      logic skipSlot;
      logic unusedSeqPc;
      assign skipSlot     = predTaken[g] & condDelay[g];
      assign immMiss[g]   = badCtrl | (targetMiss & skipSlot);
      assign deferMiss[g] = targetMiss & ~skipSlot;
      assign takenFlag[g] = predNextNext[g] != (predTarget[g] + STEP);
      assign unusedSeqPc  = ^seqPc;
    end else begin : g_plain
      logic unusedDelayIn;
      assign immMiss[g]    = badCtrl | targetMiss;
      assign deferMiss[g]  = 1'b0;
      assign takenFlag[g]  = predTarget[g] != seqPc;
      assign unusedDelayIn = ^{predNextNext[g], condDelay[g]};
    end
  end

endmodule

// File: rtl/bdc_ctrl.sv
module bdc_ctrl
  import bdc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TID_W = 2
) (
  input  logic [WIDTH-1:0]            slotValid,
  input  logic [WIDTH-1:0][TID_W-1:0] slotTid,
  input  logic [WIDTH-1:0]            immMiss,
  input  logic [WIDTH-1:0]            deferMiss,
  input  logic [WIDTH-1:0]            resolved,
  input  logic                        pendValid,
  input  logic [TID_W-1:0]            pendTid,
  output bdcStrobe_t                  strobe
);

  logic                    halted;
  logic                    armed;
  logic [TID_W-1:0]        armTid;
  logic [STROBE_IDX_W-1:0] armSel;

  // scan slots in program order; the first trigger ends checking
  always_comb begin
    strobe = '0;
    halted = 1'b0;
    armed  = 1'b0;
    armTid = '0;
    armSel = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (slotValid[i] && !halted) begin
        if (pendValid) begin
          // deferred branch from an earlier group waits for its delay slot
          if (slotTid[i] == pendTid) begin
            strobe.fire     = 1'b1;
            strobe.useSaved = 1'b1;
            halted          = 1'b1;
          end
        end else if (armed) begin
          if (slotTid[i] == armTid) begin
            strobe.fire    = 1'b1;
            strobe.plusOne = 1'b1;
            strobe.sel     = armSel;
            halted         = 1'b1;
          end
        end else if (immMiss[i]) begin
          strobe.fire   = 1'b1;
          strobe.sel    = STROBE_IDX_W'(i);
          strobe.misInc = strobe.misInc + 1'b1;
          strobe.resInc = strobe.resInc + {{(STROBE_IDX_W-1){1'b0}}, resolved[i]};
          halted        = 1'b1;
        end else if (deferMiss[i]) begin
          armed         = 1'b1;
          armTid        = slotTid[i];
          armSel        = STROBE_IDX_W'(i);
          strobe.misInc = strobe.misInc + 1'b1;
          strobe.resInc = strobe.resInc + 1'b1;
        end else begin
          strobe.resInc = strobe.resInc + {{(STROBE_IDX_W-1){1'b0}}, resolved[i]};
        end
      end
    end
    if (armed && !strobe.fire) begin
      strobe.pendLoad = 1'b1;
      strobe.sel      = armSel;
    end
  end

endmodule

// File: rtl/bdc_datapath.sv
module bdc_datapath
  import bdc_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 2,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bdcStrobe_t                  strobe,
  input  logic [WIDTH-1:0]            slotValid,
  input  logic [WIDTH-1:0][TID_W-1:0] slotTid,
  input  logic [WIDTH-1:0][SEQ_W-1:0] slotSeq,
  input  logic [WIDTH-1:0][PC_W-1:0]  fixTarget,
  input  logic [WIDTH-1:0]            takenFlag,
  output logic                        pendValid,
  output logic [TID_W-1:0]            pendTid,
  output logic                        redirValid,
  output logic [TID_W-1:0]            redirTid,
  output logic [PC_W-1:0]             redirNextPc,
  output logic [PC_W-1:0]             redirNextNextPc,
  output logic                        redirTaken,
  output logic [SEQ_W-1:0]            squashSeq,
  output logic [WIDTH-1:0]            killMask,
  output logic [CNT_W-1:0]            mispredCount,
  output logic [CNT_W-1:0]            resolvedCount
);

  localparam int IDX_W = $clog2(WIDTH);

  logic [IDX_W-1:0] selIdx;
  logic             unusedSelHigh;
  logic [SEQ_W-1:0] pendSeq;
  logic [PC_W-1:0]  pendTarget;
  logic             pendTaken;

  logic [PC_W-1:0]  srcTarget;
  logic             srcTaken;
  logic [TID_W-1:0] srcTid;
  logic [SEQ_W-1:0] srcSeq;
  logic [SEQ_W-1:0] bound;
  logic [WIDTH-1:0] killNext;

  assign selIdx        = strobe.sel[IDX_W-1:0];
  assign unusedSelHigh = ^strobe.sel;

  always_comb begin
    if (strobe.useSaved) begin
      srcTarget = pendTarget;
      srcTaken  = pendTaken;
      srcTid    = pendTid;
      srcSeq    = pendSeq;
    end else begin
      srcTarget = fixTarget[selIdx];
      srcTaken  = takenFlag[selIdx];
      srcTid    = slotTid[selIdx];
      srcSeq    = slotSeq[selIdx];
    end
    bound = srcSeq + {{(SEQ_W-1){1'b0}}, (strobe.useSaved | strobe.plusOne)};
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_kill
    assign killNext[g] = strobe.fire & slotValid[g] &
                         (slotTid[g] == srcTid) & (slotSeq[g] > bound);
  end

  // deferred-branch holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendTid    <= '0;
      pendSeq    <= '0;
      pendTarget <= '0;
      pendTaken  <= 1'b0;
    end else if (strobe.fire && strobe.useSaved) begin
      pendValid <= 1'b0;
    end else if (strobe.pendLoad) begin
      pendValid  <= 1'b1;
      pendTid    <= slotTid[selIdx];
      pendSeq    <= slotSeq[selIdx];
      pendTarget <= fixTarget[selIdx];
      pendTaken  <= takenFlag[selIdx];
    end
  end

  // registered redirect and counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirValid      <= 1'b0;
      redirTid        <= '0;
      redirNextPc     <= '0;
      redirNextNextPc <= '0;
      redirTaken      <= 1'b0;
      squashSeq       <= '0;
      killMask        <= '0;
      mispredCount    <= '0;
      resolvedCount   <= '0;
    end else begin
      redirValid    <= strobe.fire;
      killMask      <= killNext;
      mispredCount  <= mispredCount + CNT_W'(strobe.misInc);
      resolvedCount <= resolvedCount + CNT_W'(strobe.resInc);
      if (strobe.fire) begin
        redirTid        <= srcTid;
        redirNextPc     <= srcTarget;
        redirNextNextPc <= srcTarget + PC_W'(INST_BYTES);
        redirTaken      <= srcTaken;
        squashSeq       <= bound;
      end
    end
  end

endmodule

// File: rtl/branch_redirect_check.sv
module branch_redirect_check
  import bdc_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 2,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b0,
  parameter int CNT_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WIDTH-1:0]            slotValid,
  input  logic [WIDTH-1:0][TID_W-1:0] slotTid,
  input  logic [WIDTH-1:0][SEQ_W-1:0] slotSeq,
  input  logic [WIDTH-1:0]            isCtrl,
  input  logic [WIDTH-1:0]            isDirect,
  input  logic [WIDTH-1:0]            isUncond,
  input  logic [WIDTH-1:0]            predTaken,
  input  logic [WIDTH-1:0]            condDelay,
  input  logic [WIDTH-1:0][PC_W-1:0]  pc,
  input  logic [WIDTH-1:0][PC_W-1:0]  predTarget,
  input  logic [WIDTH-1:0][PC_W-1:0]  predNextNext,
  input  logic [WIDTH-1:0][PC_W-1:0]  calcTarget,
  output logic                        redirValid,
  output logic [TID_W-1:0]            redirTid,
  output logic [PC_W-1:0]             redirNextPc,
  output logic [PC_W-1:0]             redirNextNextPc,
  output logic                        redirTaken,
  output logic [SEQ_W-1:0]            squashSeq,
  output logic [WIDTH-1:0]            killMask,
  output logic [CNT_W-1:0]            mispredCount,
  output logic [CNT_W-1:0]            resolvedCount
);

  logic [WIDTH-1:0]           immMiss;
  logic [WIDTH-1:0]           deferMiss;
  logic [WIDTH-1:0]           resolved;
  logic [WIDTH-1:0][PC_W-1:0] fixTarget;
  logic [WIDTH-1:0]           takenFlag;
  logic                       pendValid;
  logic [TID_W-1:0]           pendTid;
  bdcStrobe_t                 strobe;

  bdc_classify #(
    .WIDTH(WIDTH), .PC_W(PC_W), .INST_BYTES(INST_BYTES), .DELAY_SLOT(DELAY_SLOT)
  ) u_classify (
    .slotValid(slotValid), .isCtrl(isCtrl), .isDirect(isDirect), .isUncond(isUncond),
    .predTaken(predTaken), .condDelay(condDelay), .pc(pc), .predTarget(predTarget),
    .predNextNext(predNextNext), .calcTarget(calcTarget),
    .immMiss(immMiss), .deferMiss(deferMiss), .resolved(resolved),
    .fixTarget(fixTarget), .takenFlag(takenFlag)
  );

  bdc_ctrl #(.WIDTH(WIDTH), .TID_W(TID_W)) u_ctrl (
    .slotValid(slotValid), .slotTid(slotTid), .immMiss(immMiss),
    .deferMiss(deferMiss), .resolved(resolved), .pendValid(pendValid),
    .pendTid(pendTid), .strobe(strobe)
  );

  bdc_datapath #(
    .WIDTH(WIDTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .PC_W(PC_W),
    .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotValid(slotValid),
    .slotTid(slotTid), .slotSeq(slotSeq), .fixTarget(fixTarget),
    .takenFlag(takenFlag), .pendValid(pendValid), .pendTid(pendTid),
    .redirValid(redirValid), .redirTid(redirTid), .redirNextPc(redirNextPc),
    .redirNextNextPc(redirNextNextPc), .redirTaken(redirTaken),
    .squashSeq(squashSeq), .killMask(killMask), .mispredCount(mispredCount),
    .resolvedCount(resolvedCount)
  );

endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
  parameter int WIDTH      = 4,
  parameter int CNT_W      = 16,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] slotValid,
  input logic             redirValid,
  input logic [WIDTH-1:0] killMask,
  input logic [CNT_W-1:0] mispredCount,
  input logic [CNT_W-1:0] resolvedCount
);

  // R5: slots are only marked alongside a redirect
  a_r5_kill_with_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (|killMask) |-> redirValid);

  // R5: only slots that held an instruction can be marked
  a_r5_kill_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    (killMask & ~$past(slotValid)) == '0);

  // R12: a redirect always follows a presented group
  a_r12_redirect_from_group: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> $past(|slotValid));

  // R11: counters advance by at most one group's worth
  a_r11_mis_step: assert property (@(posedge clk) disable iff (!rstN)
    (mispredCount - $past(mispredCount)) <= CNT_W'(WIDTH));

  a_r11_res_step: assert property (@(posedge clk) disable iff (!rstN)
    (resolvedCount - $past(resolvedCount)) <= CNT_W'(WIDTH));

  // R11: without delay slots every redirect is a counted wrong prediction
  if (!DELAY_SLOT) begin : g_nd
    a_r11_redirect_counted: assert property (@(posedge clk) disable iff (!rstN)
      redirValid |-> (mispredCount != $past(mispredCount)));
  end

endmodule

bind branch_redirect_check bdc_checker #(
  .WIDTH(WIDTH), .CNT_W(CNT_W), .DELAY_SLOT(DELAY_SLOT)
) u_bdc_checker (
  .clk(clk), .rstN(rstN), .slotValid(slotValid), .redirValid(redirValid),
  .killMask(killMask), .mispredCount(mispredCount), .resolvedCount(resolvedCount)
);

// File: tb/test_branch_redirect_check.sv
module test_branch_redirect_check;

  localparam int W  = 4;
  localparam int SW = 16;
  localparam int TW = 2;
  localparam int PW = 32;
  localparam int CW = 16;

  typedef struct packed {
    logic          c, d, u, pt, cd;
    logic [31:0]   pcv, ptg, pnn, calc;
    logic          expNd;
    logic [1:0]    dsKind;   // 0 none, 1 immediate, 2 deferred
    logic [31:0]   expTgt;
    logic          tkNd, tkDs;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{0,0,0,0,0, 32'h100,32'h104,32'h108,32'h104, 0,2'd0, 32'h0,  0,0},
    '{0,0,0,1,0, 32'h100,32'h200,32'h204,32'h0,   1,2'd1, 32'h104,1,0},
    '{1,1,1,1,0, 32'h100,32'h300,32'h304,32'h300, 0,2'd0, 32'h0,  0,0},
    '{1,1,1,0,0, 32'h100,32'h104,32'h108,32'h400, 1,2'd2, 32'h400,0,0},
    '{1,1,1,1,1, 32'h100,32'h500,32'h504,32'h600, 1,2'd1, 32'h600,1,0},
    '{1,1,1,1,0, 32'h100,32'h500,32'h700,32'h680, 1,2'd2, 32'h680,1,1},
    '{1,1,0,0,0, 32'h100,32'h104,32'h108,32'h780, 0,2'd0, 32'h0,  0,0},
    '{1,0,1,1,0, 32'h100,32'h800,32'h804,32'h880, 0,2'd0, 32'h0,  0,0},
    '{0,1,1,0,0, 32'h100,32'h104,32'h108,32'h900, 0,2'd0, 32'h0,  0,0},
    '{1,1,0,1,0, 32'h100,32'hA00,32'hA04,32'hA80, 0,2'd0, 32'h0,  0,0}
  };

  logic clk = 1'b0;
  logic rstN;
  always #10 clk = ~clk;

  logic [W-1:0]          slotValid, isCtrl, isDirect, isUncond, predTaken, condDelay;
  logic [W-1:0][TW-1:0]  slotTid;
  logic [W-1:0][SW-1:0]  slotSeq;
  logic [W-1:0][PW-1:0]  pc, predTarget, predNextNext, calcTarget;

  logic          ndValid, dsValid, ndTaken, dsTaken;
  logic [TW-1:0] ndTid, dsTid;
  logic [PW-1:0] ndNpc, dsNpc, ndNnpc, dsNnpc;
  logic [SW-1:0] ndSeq, dsSeq;
  logic [W-1:0]  ndKill, dsKill;
  logic [CW-1:0] ndMis, dsMis, ndRes, dsRes;

  branch_redirect_check #(.DELAY_SLOT(1'b0)) i_branch_redirect_check (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotTid(slotTid), .slotSeq(slotSeq),
    .isCtrl(isCtrl), .isDirect(isDirect), .isUncond(isUncond), .predTaken(predTaken),
    .condDelay(condDelay), .pc(pc), .predTarget(predTarget), .predNextNext(predNextNext),
    .calcTarget(calcTarget), .redirValid(ndValid), .redirTid(ndTid), .redirNextPc(ndNpc),
    .redirNextNextPc(ndNnpc), .redirTaken(ndTaken), .squashSeq(ndSeq), .killMask(ndKill),
    .mispredCount(ndMis), .resolvedCount(ndRes));

  branch_redirect_check #(.DELAY_SLOT(1'b1)) i_branch_redirect_check_ds (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotTid(slotTid), .slotSeq(slotSeq),
    .isCtrl(isCtrl), .isDirect(isDirect), .isUncond(isUncond), .predTaken(predTaken),
    .condDelay(condDelay), .pc(pc), .predTarget(predTarget), .predNextNext(predNextNext),
    .calcTarget(calcTarget), .redirValid(dsValid), .redirTid(dsTid), .redirNextPc(dsNpc),
    .redirNextNextPc(dsNnpc), .redirTaken(dsTaken), .squashSeq(dsSeq), .killMask(dsKill),
    .mispredCount(dsMis), .resolvedCount(dsRes));

  int total = 0;
  int bad   = 0;
  int expMisNd = 0, expMisDs = 0, expResNd = 0, expResDs = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearSlots();
    slotValid = '0; isCtrl = '0; isDirect = '0; isUncond = '0;
    predTaken = '0; condDelay = '0; slotTid = '0; slotSeq = '0;
    pc = '0; predTarget = '0; predNextNext = '0; calcTarget = '0;
  endtask

  task automatic putSlot(int s, int tid, int seq, logic c, logic d, logic u,
                         logic pt, logic cd, logic [31:0] pcv, logic [31:0] ptg,
                         logic [31:0] pnn, logic [31:0] calc);
    slotValid[s] = 1'b1; slotTid[s] = TW'(tid); slotSeq[s] = SW'(seq);
    isCtrl[s] = c; isDirect[s] = d; isUncond[s] = u; predTaken[s] = pt;
    condDelay[s] = cd; pc[s] = pcv; predTarget[s] = ptg;
    predNextNext[s] = pnn; calcTarget[s] = calc;
  endtask

  task automatic plain(int s, int tid, int seq);
    putSlot(s, tid, seq, 0, 0, 0, 0, 0, 32'h40, 32'h44, 32'h48, 32'h0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // compare one copy's outputs with an expected redirect
  task automatic checkRedir(bit ds, string req, bit eV, logic [31:0] eT, bit eTk,
                            int eTid, int eSeq, logic [3:0] eK);
    string m;
    m = ds ? "ds" : "nd";
    chk(req, {m, " redirValid"}, ds ? dsValid : ndValid, eV);
    chk(req, {m, " killMask"},   ds ? dsKill  : ndKill,  eK);
    if (eV) begin
      chk(req, {m, " nextPc"},     ds ? dsNpc   : ndNpc,   eT);
      chk("R4", {m, " nextNextPc"}, ds ? dsNnpc : ndNnpc, eT + 32'd4);
      chk("R10", {m, " taken"},    ds ? dsTaken : ndTaken, eTk);
      chk(req, {m, " tid"},        ds ? dsTid   : ndTid,   eTid);
      chk(req, {m, " squashSeq"},  ds ? dsSeq   : ndSeq,   eSeq);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    clearSlots();
    repeat (3) @(negedge clk);
    // R1: state under reset
    checkRedir(0, "R1", 0, 0, 0, 0, 0, 4'b0000);
    checkRedir(1, "R1", 0, 0, 0, 0, 0, 4'b0000);
    rstN = 1'b1;
    step();
    checkRedir(0, "R1", 0, 0, 0, 0, 0, 4'b0000);
    chk("R1", "nd mispredCount", ndMis, 0);
    chk("R1", "ds resolvedCount", dsRes, 0);

    // table: row instruction in slot 0, two younger same-thread slots after it
    for (int r = 0; r < NROWS; r++) begin
      automatic row_t t = ROWS[r];
      automatic int b = 100 + r * 10;
      clearSlots();
      putSlot(0, 0, b, t.c, t.d, t.u, t.pt, t.cd, t.pcv, t.ptg, t.pnn, t.calc);
      plain(1, 0, b + 1);
      plain(2, 0, b + 2);
      step();
      // R2 R3 R5: non-delay copy squashes at the instruction
      checkRedir(0, "R3", t.expNd, t.expTgt, t.tkNd, 0, b, t.expNd ? 4'b0110 : 4'b0000);
      // R7 immediate / R8 deferred to after the delay slot
      case (t.dsKind)
        2'd1:    checkRedir(1, "R7", 1, t.expTgt, t.tkDs, 0, b, 4'b0110);
        2'd2:    checkRedir(1, "R8", 1, t.expTgt, t.tkDs, 0, b + 1, 4'b0100);
        default: checkRedir(1, "R3", 0, 0, 0, 0, 0, 4'b0000);
      endcase
      expMisNd += int'(t.expNd);
      expMisDs += int'(t.dsKind != 2'd0);
      expResNd += int'(t.c & t.d & t.u);
      expResDs += int'(t.c & t.d & t.u);
    end
    clearSlots();
    step();
    // R12: idle group after a redirect leaves no redirect
    checkRedir(0, "R12", 0, 0, 0, 0, 0, 4'b0000);
    checkRedir(1, "R12", 0, 0, 0, 0, 0, 4'b0000);
    chk("R11", "nd mispredCount after table", ndMis, expMisNd);
    chk("R11", "ds mispredCount after table", dsMis, expMisDs);
    chk("R11", "nd resolvedCount after table", ndRes, expResNd);
    chk("R11", "ds resolvedCount after table", dsRes, expResDs);

    // R5 R6: mixed threads, later mismatch of the other thread is not checked
    clearSlots();
    putSlot(0, 0, 500, 0, 0, 0, 1, 0, 32'h300, 32'h380, 32'h384, 32'h0);
    plain(1, 1, 600);
    plain(2, 0, 501);
    putSlot(3, 1, 601, 1, 1, 1, 0, 0, 32'h310, 32'h314, 32'h318, 32'hC00);
    step();
    checkRedir(0, "R5", 1, 32'h304, 1, 0, 500, 4'b0100);
    checkRedir(1, "R6", 1, 32'h304, 0, 0, 500, 4'b0100);
    expMisNd += 1; expMisDs += 1;

    // R6: first trigger in slot order wins
    clearSlots();
    plain(0, 2, 1000);
    putSlot(1, 2, 1001, 1, 1, 1, 1, 1, 32'h200, 32'h900, 32'h904, 32'hA00);
    putSlot(2, 2, 1002, 0, 0, 0, 1, 0, 32'h204, 32'h280, 32'h284, 32'h0);
    step();
    checkRedir(0, "R6", 1, 32'hA00, 1, 2, 1001, 4'b0100);
    checkRedir(1, "R6", 1, 32'hA00, 0, 2, 1001, 4'b0100);
    expMisNd += 1; expMisDs += 1; expResNd += 1; expResDs += 1;

    // R9: deferred branch is the last same-thread slot of its group
    clearSlots();
    plain(0, 0, 700);
    putSlot(1, 0, 701, 1, 1, 1, 1, 0, 32'h100, 32'h500, 32'h700, 32'h680);
    step();
    checkRedir(0, "R5", 1, 32'h680, 1, 0, 701, 4'b0000);
    checkRedir(1, "R9", 0, 0, 0, 0, 0, 4'b0000);
    expMisNd += 1; expMisDs += 1; expResNd += 1; expResDs += 1;

    clearSlots();
    putSlot(0, 1, 900, 0, 0, 0, 1, 0, 32'h900, 32'h980, 32'h984, 32'h0);
    plain(1, 0, 702);
    plain(2, 0, 703);
    step();
    checkRedir(0, "R2", 1, 32'h904, 1, 1, 900, 4'b0000);
    checkRedir(1, "R9", 1, 32'h680, 1, 0, 702, 4'b0100);
    expMisNd += 1;

    clearSlots();
    step();
    checkRedir(0, "R12", 0, 0, 0, 0, 0, 4'b0000);
    checkRedir(1, "R9", 0, 0, 0, 0, 0, 4'b0000);

    chk("R11", "nd mispredCount final", ndMis, expMisNd);
    chk("R11", "ds mispredCount final", dsMis, expMisDs);
    chk("R11", "nd resolvedCount final", ndRes, expResNd);
    chk("R11", "ds resolvedCount final", dsRes, expResDs);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule